// File: doc/BRIEF.md
# Drawing Command Packet Framer

The framer sits between a 32-bit command word stream and a renderer. It reads the opcode in bits 31:24 of each leading word, works out how many words the packet spans from a fixed per-opcode length rule, and passes the whole packet on to the renderer port. The first word of each packet carries a start marker and the last word carries an end marker. Input and output both use valid/ready handshakes.

While packets pass through, the framer watches for state-setting commands and keeps a bank of eight environment registers. Textured primitives update the texture-page bits in one of these registers. A compact status field is rebuilt from the bank each time a packet finishes.

Image transfer commands are not forwarded. Their position and size words go to a separate transfer-start port as decoded coordinates. For a write transfer, the pixel words that follow are steered to a pixel port until the transfer is complete. Parsing then resumes.

Top module: `fpk_framer`

## Requirements
- R1: The packet length in words is 1 plus an extra count chosen by the opcode. The extra count is 2 for 0x02. For 0x20–0x3F, taken in blocks of four opcodes starting at 0x20, it is 3, 6, 4, 8, 5, 8, 7, 11. For 0x40–0x5F, in blocks of eight, it is 2, 3, 3, 4. For 0x60–0x7F, in blocks of four, it is 2, 3, 1, 0, 1, 2, 1, 2. It is 3 for 0x80 and 2 for 0xA0 and 0xC0. Every other opcode has an extra count of 0.
- R2: Every non-transfer packet leaves on `out_data` unchanged and in order. `out_sop` is high on its first word and `out_eop` on its last; a one-word packet has both high.
- R3: A leading word with opcode 0xE0–0xE7 is copied whole into environment slot `opcode[2:0]`. `env_q[32*i +: 32]` shows slot i. After reset, slot i holds (0xE0+i) in bits 31:24 and zero elsewhere.
- R4: When `(opcode & 0xF4) == 0x24`, bits 8:0 of slot 1 take bits 8:0 of packet word 4 (word 0 is the opcode word). When `(opcode & 0xF4) == 0x34`, they take bits 8:0 of word 5. The other bits of slot 1 are kept. Other opcodes, such as 0x30, leave slot 1 unchanged.
- R5: `status_lo[10:0]` equals slot 1 bits 10:0 and `status_lo[12:11]` equals slot 6 bits 1:0. It is rebuilt on the clock edge after the final word of a packet or transfer header is accepted. It is zero after reset.
- R6: `frame_dirty` pulses high for one cycle, one cycle after a leading word is accepted whose opcode lies in 0x02–0xBF inclusive. No other word causes a pulse.
- R7: Opcodes 0xA0 (write) and 0xC0 (read) consume three words, none of which is forwarded. `xfer_start` then pulses for one cycle with these fields: `xfer_read` is 1 for 0xC0. `xfer_x` is position bits 9:0 and `xfer_y` is position bits 24:16. `xfer_w` is ((size[9:0]−1) mod 1024)+1 and `xfer_h` is ((size[24:16]−1) mod 512)+1.
- R8: After a write header, the next ceil(w·h/2) input words go to `pix_data` and are never forwarded. `pix_last` is high on the final one, and the word after it is parsed as an opcode. After a read header, the next word is parsed as an opcode at once.
- R9: `in_ready` is low whenever the current word is bound for the renderer and `out_ready` is low. Header words are always accepted. Pixel words follow `pix_ready`.
- R10: A reset drops any partly received packet, so the first word after reset is taken as an opcode. Reset also returns the environment slots to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted this cycle |
| out_valid | output | 1 | Renderer word valid |
| out_data | output | 32 | Renderer word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_ready | input | 1 | Renderer can take a word |
| pix_valid | output | 1 | Pixel word valid |
| pix_data | output | 32 | Pixel word (two 16-bit pixels) |
| pix_last | output | 1 | Final pixel word of the transfer |
| pix_ready | input | 1 | Transfer engine takes the pixel word |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_x | output | 10 | Transfer X position |
| xfer_y | output | 9 | Transfer Y position |
| xfer_w | output | 11 | Transfer width in pixels (1–1024) |
| xfer_h | output | 10 | Transfer height in lines (1–512) |
| frame_dirty | output | 1 | Drawing command seen pulse |
| status_lo | output | 13 | Rebuilt low status bits |
| env_q | output | 256 | Eight environment slots, slot i at bits 32*i+31:32*i |

## Verification
The assertions assume that the upstream source keeps `in_valid` and `in_data` steady until the word is accepted. They also assume that the transfer engine takes pixel words only through `pix_ready`, so the count of pixel words is fixed by the header alone. The driver holds each word until `in_ready` is seen high and never withdraws one. The renderer-side ready is varied pseudo-randomly, or held low, only on its own port. Pixel ready is held high, and transfer sizes are kept small so that every pixel run completes.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

   typedef enum logic [2:0] {
      ST_OP,
      ST_BODY,
      ST_XPOS,
      ST_XSIZE,
      ST_PIX
   } fpk_state_e;

   localparam logic [7:0] OP_VRAM_WR = 8'hA0;
   localparam logic [7:0] OP_VRAM_RD = 8'hC0;

   // extra words following the opcode word
   function automatic logic [3:0] fpk_extra(input logic [7:0] op);
      logic [3:0] e;
      e = 4'd0;
      case (op[7:5])
         3'd0: e = (op == 8'h02) ? 4'd2 : 4'd0;
         3'd1: begin
            case (op[4:2])
               3'd0: e = 4'd3;
               3'd1: e = 4'd6;
               3'd2: e = 4'd4;
               3'd3: e = 4'd8;
               3'd4: e = 4'd5;
               3'd5: e = 4'd8;
               3'd6: e = 4'd7;
               default: e = 4'd11;
            endcase
         end
         3'd2: begin
            case (op[4:3])
               2'd0: e = 4'd2;
               2'd1: e = 4'd3;
               2'd2: e = 4'd3;
               default: e = 4'd4;
            endcase
         end
         3'd3: begin
            case (op[4:2])
               3'd0: e = 4'd2;
               3'd1: e = 4'd3;
               3'd2: e = 4'd1;
               3'd3: e = 4'd0;
               3'd4: e = 4'd1;
               3'd5: e = 4'd2;
               3'd6: e = 4'd1;
               default: e = 4'd2;
            endcase
         end
         3'd4: e = (op == 8'h80) ? 4'd3 : 4'd0;
         3'd5: e = (op == OP_VRAM_WR) ? 4'd2 : 4'd0;
         3'd6: e = (op == OP_VRAM_RD) ? 4'd2 : 4'd0;
         default: e = 4'd0;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/fpk_len_lut.sv
module fpk_len_lut
   import fpk_pkg::*;
#(
   parameter int LEN_W = 4
) (
   input  logic [7:0]       op,
   output logic [LEN_W-1:0] len,
   output logic             is_xfer,
   output logic             is_env,
   output logic             dirty,
   output logic             tex_hit,
   output logic [LEN_W-1:0] tex_at
);

   if (LEN_W < 4) begin : g_len_chk
      $error("fpk_len_lut: LEN_W must hold a 12-word packet");
   end

   always_comb begin
      len     = LEN_W'(fpk_extra(op)) + LEN_W'(1);
      is_xfer = (op == OP_VRAM_WR) || (op == OP_VRAM_RD);
      is_env  = (op[7:3] == 5'b11100);
      dirty   = (op >= 8'h02) && (op < 8'hC0);
      tex_hit = 1'b0;
      tex_at  = '0;
      if ((op & 8'hF4) == 8'h24) begin
         tex_hit = 1'b1;
         tex_at  = LEN_W'(4);
      end else if ((op & 8'hF4) == 8'h34) begin
         tex_hit = 1'b1;
         tex_at  = LEN_W'(5);
      end
   end

endmodule

// File: rtl/fpk_env_file.sv
module fpk_env_file #(
   parameter int N        = 8,
   parameter int W        = 32,
   parameter int TEX_BITS = 9,
   parameter int TEX_SLOT = 1,
   localparam int IDX_W   = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_full,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [W-1:0]      wr_data,
   input  logic              wr_tex,
   input  logic [TEX_BITS-1:0] tex_data,
   output logic [N*W-1:0]    env_flat
);

   if (W < 8 || TEX_BITS >= W || TEX_SLOT >= N) begin : g_par_chk
      $error("fpk_env_file: bad width or slot parameters");
   end

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= {8'(8'hE0 + i), {(W-8){1'b0}}};
         end else if (wr_full && wr_idx == IDX_W'(i)) begin
            q <= wr_data;
         end else if (i == TEX_SLOT && wr_tex) begin
            q[TEX_BITS-1:0] <= tex_data;
         end
      end
      assign env_flat[i*W +: W] = q;
   end

endmodule

// File: rtl/fpk_xfer_geom.sv
module fpk_xfer_geom #(
   parameter int X_W    = 10,
   parameter int Y_W    = 9,
   localparam int WW    = X_W + 1,
   localparam int HW    = Y_W + 1,
   localparam int PIX_W = WW + HW
) (
   input  logic [X_W-1:0]   w_field,
   input  logic [Y_W-1:0]   h_field,
   output logic [WW-1:0]    w,
   output logic [HW-1:0]    h,
   output logic [PIX_W-1:0] words
);

   logic [X_W-1:0]   w_m1;
   logic [Y_W-1:0]   h_m1;
   logic [PIX_W-1:0] pix;

   always_comb begin
      w_m1  = w_field - X_W'(1);
      h_m1  = h_field - Y_W'(1);
      w     = {1'b0, w_m1} + WW'(1);
      h     = {1'b0, h_m1} + HW'(1);
      pix   = PIX_W'(w) * PIX_W'(h);
      words = (pix + PIX_W'(1)) >> 1;
   end

endmodule

// File: rtl/fpk_framer.sv
module fpk_framer
   import fpk_pkg::*;
#(
   parameter int ENV_N     = 8,
   parameter int TEX_BITS  = 9,
   parameter int STAT_LO_W = 11,
   parameter int STAT_HI_W = 2,
   parameter int LEN_W     = 4,
   parameter int X_W       = 10,
   parameter int Y_W       = 9,
   localparam int DW       = 32,
   localparam int STAT_W   = STAT_LO_W + STAT_HI_W,
   localparam int IDX_W    = $clog2(ENV_N),
   localparam int PIX_W    = X_W + Y_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DW-1:0]       in_data,
   output logic                in_ready,
   output logic                out_valid,
   output logic [DW-1:0]       out_data,
   output logic                out_sop,
   output logic                out_eop,
   input  logic                out_ready,
   output logic                pix_valid,
   output logic [DW-1:0]       pix_data,
   output logic                pix_last,
   input  logic                pix_ready,
   output logic                xfer_start,
   output logic                xfer_read,
   output logic [X_W-1:0]      xfer_x,
   output logic [Y_W-1:0]      xfer_y,
   output logic [X_W:0]        xfer_w,
   output logic [Y_W:0]        xfer_h,
   output logic                frame_dirty,
   output logic [STAT_W-1:0]   status_lo,
   output logic [ENV_N*DW-1:0] env_q
);

   if (ENV_N != 8 || STAT_W != 13 || X_W + 16 > DW || Y_W + 16 > DW) begin : g_top_chk
      $error("fpk_framer: unsupported parameter set");
   end

   localparam int SLOT_TEX = 1;
   localparam int SLOT_HI  = 6;

   fpk_state_e        state;
   logic [LEN_W-1:0]  remain;
   logic [LEN_W-1:0]  idx;
   logic              tex_q;
   logic [LEN_W-1:0]  tex_at_q;
   logic              rd_q;
   logic [X_W-1:0]    pos_x_q;
   logic [Y_W-1:0]    pos_y_q;
   logic [PIX_W-1:0]  pix_left;
   logic              stat_pend;

   logic [LEN_W-1:0]  lut_len;
   logic              lut_xfer, lut_env, lut_dirty, lut_tex;
   logic [LEN_W-1:0]  lut_tex_at;
   logic              acc;
   logic              env_wr, tex_wr;
   logic [X_W:0]      g_w;
   logic [Y_W:0]      g_h;
   logic [PIX_W-1:0]  g_words;
   logic              last_word;

   fpk_len_lut #(.LEN_W(LEN_W)) u_lut (
      .op      (in_data[31:24]),
      .len     (lut_len),
      .is_xfer (lut_xfer),
      .is_env  (lut_env),
      .dirty   (lut_dirty),
      .tex_hit (lut_tex),
      .tex_at  (lut_tex_at)
   );

   fpk_xfer_geom #(.X_W(X_W), .Y_W(Y_W)) u_geom (
      .w_field (in_data[X_W-1:0]),
      .h_field (in_data[16 +: Y_W]),
      .w       (g_w),
      .h       (g_h),
      .words   (g_words)
   );

   fpk_env_file #(
      .N        (ENV_N),
      .W        (DW),
      .TEX_BITS (TEX_BITS),
      .TEX_SLOT (SLOT_TEX)
   ) u_env (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_full  (env_wr),
      .wr_idx   (in_data[24 +: IDX_W]),
      .wr_data  (in_data),
      .wr_tex   (tex_wr),
      .tex_data (in_data[TEX_BITS-1:0]),
      .env_flat (env_q)
   );

   // routing of the current word
   always_comb begin
      in_ready  = 1'b0;
      out_valid = 1'b0;
      out_sop   = 1'b0;
      out_eop   = 1'b0;
      pix_valid = 1'b0;
      case (state)
         ST_OP: begin
            if (lut_xfer) begin
               in_ready = 1'b1;
            end else begin
               out_valid = in_valid;
               in_ready  = out_ready;
               out_sop   = 1'b1;
               out_eop   = (lut_len == LEN_W'(1));
            end
         end
         ST_BODY: begin
            out_valid = in_valid;
            in_ready  = out_ready;
            out_eop   = (remain == LEN_W'(1));
         end
         ST_XPOS, ST_XSIZE: in_ready = 1'b1;
         ST_PIX: begin
            pix_valid = in_valid;
            in_ready  = pix_ready;
         end
         default: in_ready = 1'b0;
      endcase
   end

   assign out_data = in_data;
   assign pix_data = in_data;
   assign pix_last = (state == ST_PIX) && (pix_left == PIX_W'(1));
   assign acc      = in_valid && in_ready;
   assign env_wr   = acc && (state == ST_OP) && lut_env;
   assign tex_wr   = acc && (state == ST_BODY) && tex_q && (idx == tex_at_q);

   always_comb begin
      last_word = 1'b0;
      if (acc) begin
         case (state)
            ST_OP:    last_word = !lut_xfer && (lut_len == LEN_W'(1));
            ST_BODY:  last_word = (remain == LEN_W'(1));
            ST_XSIZE: last_word = 1'b1;
            default:  last_word = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_OP;
         remain      <= '0;
         idx         <= '0;
         tex_q       <= 1'b0;
         tex_at_q    <= '0;
         rd_q        <= 1'b0;
         pos_x_q     <= '0;
         pos_y_q     <= '0;
         pix_left    <= '0;
         stat_pend   <= 1'b0;
         status_lo   <= '0;
         frame_dirty <= 1'b0;
         xfer_start  <= 1'b0;
         xfer_read   <= 1'b0;
         xfer_x      <= '0;
         xfer_y      <= '0;
         xfer_w      <= '0;
         xfer_h      <= '0;
      end else begin
         frame_dirty <= acc && (state == ST_OP) && lut_dirty;
         xfer_start  <= 1'b0;
         stat_pend   <= last_word;
         if (stat_pend) begin
            status_lo <= {env_q[SLOT_HI*DW +: STAT_HI_W],
                          env_q[SLOT_TEX*DW +: STAT_LO_W]};
         end
         if (acc) begin
            case (state)
               ST_OP: begin
                  if (lut_xfer) begin
                     rd_q  <= (in_data[31:24] == OP_VRAM_RD);
                     state <= ST_XPOS;
                  end else if (lut_len != LEN_W'(1)) begin
                     remain   <= lut_len - LEN_W'(1);
                     idx      <= LEN_W'(1);
                     tex_q    <= lut_tex;
                     tex_at_q <= lut_tex_at;
                     state    <= ST_BODY;
                  end
               end
               ST_BODY: begin
                  remain <= remain - LEN_W'(1);
                  idx    <= idx + LEN_W'(1);
                  if (remain == LEN_W'(1)) begin
                     state <= ST_OP;
                  end
               end
               ST_XPOS: begin
                  pos_x_q <= in_data[X_W-1:0];
                  pos_y_q <= in_data[16 +: Y_W];
                  state   <= ST_XSIZE;
               end
               ST_XSIZE: begin
                  xfer_start <= 1'b1;
                  xfer_read  <= rd_q;
                  xfer_x     <= pos_x_q;
                  xfer_y     <= pos_y_q;
                  xfer_w     <= g_w;
                  xfer_h     <= g_h;
                  pix_left   <= g_words;
                  state      <= rd_q ? ST_OP : ST_PIX;
               end
               ST_PIX: begin
                  pix_left <= pix_left - PIX_W'(1);
                  if (pix_left == PIX_W'(1)) begin
                     state <= ST_OP;
                  end
               end
               default: state <= ST_OP;
            endcase
         end
      end
   end

endmodule

// File: rtl/fpk_framer_chk.sv
module fpk_framer_chk (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid,
   input logic out_ready,
   input logic pix_valid,
   input logic pix_ready,
   input logic pix_last,
   input logic xfer_start,
   input logic xfer_read,
   input logic frame_dirty
);

   logic wr_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_open <= 1'b0;
      end else if (xfer_start && !xfer_read) begin
         wr_open <= 1'b1;
      end else if (pix_valid && pix_ready && pix_last) begin
         wr_open <= 1'b0;
      end
   end

   AST_STALL_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R9

   AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_valid, pix_valid})); // R8

   AST_PIX_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (wr_open || xfer_start)); // R8

   AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start); // R7

   AST_DIRTY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_dirty |-> $past(in_valid && in_ready)); // R6

endmodule

bind fpk_framer fpk_framer_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .pix_valid   (pix_valid),
   .pix_ready   (pix_ready),
   .pix_last    (pix_last),
   .xfer_start  (xfer_start),
   .xfer_read   (xfer_read),
   .frame_dirty (frame_dirty)
);

// File: tb/fpk_framer_test.sv
module fpk_framer_test;
   localparam int CLK_NS = 10;
   localparam int Q      = CLK_NS / 4;

   typedef struct packed {
      logic        sop;
      logic        eop;
      logic [31:0] d;
   } beat_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  in_data = '0;
   logic         in_ready;
   logic         out_valid, out_sop, out_eop;
   logic [31:0]  out_data;
   logic         out_ready = 1'b1;
   logic         pix_valid, pix_last;
   logic [31:0]  pix_data;
   logic         pix_ready = 1'b1;
   logic         xfer_start, xfer_read;
   logic [9:0]   xfer_x;
   logic [8:0]   xfer_y;
   logic [10:0]  xfer_w;
   logic [9:0]   xfer_h;
   logic         frame_dirty;
   logic [12:0]  status_lo;
   logic [255:0] env_q;

   int    n_chk = 0;
   int    n_bad = 0;
   int    stall_mode = 0;
   int    dirty_cnt = 0;
   int    xfer_cnt = 0;
   logic  cap_rd;
   logic [9:0]  cap_x;
   logic [8:0]  cap_y;
   logic [10:0] cap_w;
   logic [9:0]  cap_h;
   beat_t exp_q[$];
   beat_t pix_q[$];

   fpk_framer uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
      .out_eop(out_eop), .out_ready(out_ready),
      .pix_valid(pix_valid), .pix_data(pix_data), .pix_last(pix_last),
      .pix_ready(pix_ready),
      .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_x(xfer_x),
      .xfer_y(xfer_y), .xfer_w(xfer_w), .xfer_h(xfer_h),
      .frame_dirty(frame_dirty), .status_lo(status_lo), .env_q(env_q)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R1: packet length written from the requirement
   function automatic int blen(input logic [7:0] op);
      int b;
      b = 0;
      if (op == 8'h02) b = 2;
      else if (op >= 8'h20 && op <= 8'h3F) begin
         int t[8] = '{3, 6, 4, 8, 5, 8, 7, 11};
         b = t[(op - 8'h20) / 4];
      end else if (op >= 8'h40 && op <= 8'h5F) begin
         int t2[4] = '{2, 3, 3, 4};
         b = t2[(op - 8'h40) / 8];
      end else if (op >= 8'h60 && op <= 8'h7F) begin
         int t3[8] = '{2, 3, 1, 0, 1, 2, 1, 2};
         b = t3[(op - 8'h60) / 4];
      end else if (op == 8'h80) b = 3;
      else if (op == 8'hA0 || op == 8'hC0) b = 2;
      return b + 1;
   endfunction

   // renderer ready pattern, changed just after each rising edge
   initial forever begin
      @(posedge clk);
      #1;
      if (stall_mode == 2) out_ready = 1'b0;
      else if (stall_mode == 1) out_ready = ($urandom % 3) != 0;
      else out_ready = 1'b1;
   end

   // monitor / scoreboard
   initial forever begin
      @(negedge clk);
      #Q;
      if (rst_n) begin
         if (out_valid && out_ready) begin
            beat_t b, e;
            b = '{out_sop, out_eop, out_data};
            if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", 64'(b), 0);
            else begin
               e = exp_q.pop_front();
               chk(b == e, "R2 R1 forwarded word", 64'(b), 64'(e));
            end
         end
         if (pix_valid && pix_ready) begin
            beat_t b, e;
            b = '{1'b0, pix_last, pix_data};
            if (pix_q.size() == 0) chk(1'b0, "R8 unexpected pixel", 64'(b), 0);
            else begin
               e = pix_q.pop_front();
               chk(b == e, "R8 pixel word", 64'(b), 64'(e));
            end
         end
         if (frame_dirty) dirty_cnt++;
         if (xfer_start) begin
            xfer_cnt++;
            cap_rd = xfer_read; cap_x = xfer_x; cap_y = xfer_y;
            cap_w = xfer_w; cap_h = xfer_h;
         end
      end
   end

   task automatic put(input logic [31:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      forever begin
         #Q;
         if (in_ready) begin
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pkt(input logic [31:0] w0, input logic [31:0] base);
      int n;
      n = blen(w0[31:24]);
      for (int i = 0; i < n; i++)
         exp_q.push_back('{i == 0, i == n - 1, (i == 0) ? w0 : base + 32'(i)});
      put(w0);
      for (int i = 1; i < n; i++) put(base + 32'(i));
   endtask

   task automatic xfer(input logic [7:0] op, input logic [31:0] pos,
                       input logic [31:0] size, input int words);
      for (int i = 0; i < words; i++)
         pix_q.push_back('{1'b0, i == words - 1, 32'h5000_0000 + 32'(i)});
      put({op, 24'h0});
      put(pos);
      put(size);
      for (int i = 0; i < words; i++) put(32'h5000_0000 + 32'(i));
   endtask

   function automatic logic [31:0] slot(input int i);
      return env_q[32*i +: 32];
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #Q;
      chk(status_lo == 13'h0, "R5 reset status", 64'(status_lo), 0);
      chk(slot(3) == 32'hE300_0000, "R3 reset slot3", 64'(slot(3)), 64'hE300_0000);
      rst_n = 1'b1;

      // R1 R2: various lengths, no stall then random stall
      pkt(32'h0000_0000, 32'h0);
      pkt(32'h0211_2233, 32'h100);
      pkt(32'h2000_0001, 32'h200);
      pkt(32'h3C00_0002, 32'h300);
      pkt(32'h4C00_0003, 32'h400);
      stall_mode = 1;
      pkt(32'h6800_0004, 32'h500);
      pkt(32'h6C00_0005, 32'h600);
      pkt(32'h8000_0006, 32'h700);
      pkt(32'h5F00_0007, 32'h800);
      pkt(32'h7C00_0008, 32'h900);
      stall_mode = 0;
      idle(3);
      chk(exp_q.size() == 0, "R2 all words seen", 64'(exp_q.size()), 0);

      // R3 R5: environment slots and status rebuild
      pkt(32'hE100_0ABC, 32'h0);
      pkt(32'hE600_0003, 32'h0);
      pkt(32'hE301_2345, 32'h0);
      idle(3);
      chk(slot(3) == 32'hE301_2345, "R3 slot3 write", 64'(slot(3)), 64'hE301_2345);
      chk(slot(1) == 32'hE100_0ABC, "R3 slot1 write", 64'(slot(1)), 64'hE100_0ABC);
      chk(status_lo == 13'h1ABC, "R5 status rebuild", 64'(status_lo), 64'h1ABC);

      // R4: texture bits from word 4 / word 5
      pkt(32'hE100_0600, 32'h0);
      pkt(32'h2400_0000, 32'h1234_5000);
      idle(3);
      chk(slot(1) == 32'hE100_0604, "R4 flat textured word4", 64'(slot(1)), 64'hE100_0604);
      chk(status_lo == 13'h1E04, "R5 status after texture", 64'(status_lo), 64'h1E04);
      pkt(32'h3400_0000, 32'hABCD_01F0);
      idle(3);
      chk(slot(1) == 32'hE100_07F5, "R4 shaded textured word5", 64'(slot(1)), 64'hE100_07F5);
      pkt(32'h3000_0000, 32'h0000_0000);
      idle(3);
      chk(slot(1) == 32'hE100_07F5, "R4 untextured ignored", 64'(slot(1)), 64'hE100_07F5);

      // R6: dirty pulses
      dirty_cnt = 0;
      pkt(32'h0200_0000, 32'h0);
      pkt(32'hE200_0000, 32'h0);
      pkt(32'h0100_0000, 32'h0);
      pkt(32'hBF00_0000, 32'h0);
      xfer(8'hC0, 32'h0, 32'h0001_0001, 0);
      idle(3);
      chk(dirty_cnt == 2, "R6 dirty count", 64'(dirty_cnt), 2);

      // R7 R8: write transfer 3x3 -> 5 pixel words
      xfer_cnt = 0;
      xfer(8'hA0, 32'h0010_0020, 32'h0003_0003, 5);
      pkt(32'h0000_0011, 32'h0);
      idle(3);
      chk(xfer_cnt == 1, "R7 one start pulse", 64'(xfer_cnt), 1);
      chk({cap_rd, cap_x, cap_y, cap_w, cap_h} == {1'b0, 10'h20, 9'h10, 11'd3, 10'd3},
          "R7 write geometry", 64'({cap_rd, cap_x, cap_y, cap_w, cap_h}),
          64'({1'b0, 10'h20, 9'h10, 11'd3, 10'd3}));
      chk(pix_q.size() == 0 && exp_q.size() == 0, "R8 pixels then opcode",
          64'(pix_q.size()), 0);

      // R7: read transfer with wrapping size, no diversion
      xfer(8'hC0, 32'h01FF_03FF, 32'h0000_0000, 0);
      pkt(32'h0000_0022, 32'h0);
      idle(3);
      chk({cap_rd, cap_x, cap_y, cap_w, cap_h} == {1'b1, 10'h3FF, 9'h1FF, 11'd1024, 10'd512},
          "R7 read geometry", 64'({cap_rd, cap_x, cap_y, cap_w, cap_h}),
          64'({1'b1, 10'h3FF, 9'h1FF, 11'd1024, 10'd512}));
      chk(exp_q.size() == 0, "R8 read resumes parsing", 64'(exp_q.size()), 0);

      // R8: single pixel word transfer
      xfer(8'hA0, 32'h0, 32'h0001_0001, 1);
      pkt(32'h0000_0033, 32'h0);
      idle(3);
      chk(pix_q.size() == 0 && exp_q.size() == 0, "R8 one-word transfer",
          64'(pix_q.size()), 0);

      // R9: stall blocks input
      stall_mode = 2;
      repeat (2) @(posedge clk);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 32'h0000_0044;
      #Q;
      chk(out_valid && !in_ready, "R9 ready low under stall",
          64'({out_valid, in_ready}), 64'b10);
      exp_q.push_back('{1'b1, 1'b1, 32'h0000_0044});
      stall_mode = 0;
      put(32'h0000_0044);
      idle(3);
      chk(exp_q.size() == 0, "R9 word passes after stall", 64'(exp_q.size()), 0);

      // R10: reset mid-packet
      exp_q.push_back('{1'b1, 1'b0, 32'h3C00_0000});
      exp_q.push_back('{1'b0, 1'b0, 32'h0000_0001});
      put(32'h3C00_0000);
      put(32'h0000_0001);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(slot(3) == 32'hE300_0000, "R10 slots back to reset", 64'(slot(3)), 64'hE300_0000);
      pkt(32'h0000_0055, 32'h0);
      idle(3);
      chk(exp_q.size() == 0, "R10 opcode after reset", 64'(exp_q.size()), 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_NS * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule